// File: doc/BRIEF.md
# Quadrature Rotary Knob Decoder

This block reads the two contact lines of a mechanical incremental rotary knob and turns them into an 8-bit position count plus a one-cycle pulse for every detent step, with one pulse line per direction. The contact lines are asynchronous to the system clock and bounce when they switch. Each line therefore passes through its own flop synchroniser and its own hold-time filter before a small step detector looks at it.

The filter on each line moves its clean level only after the synchronised input has disagreed with it for `HOLD_CYCLES` samples in a row. The default of 25,000 cycles at 50 MHz is 0.5 ms. That is longer than the roughly 0.2 ms dropouts the contacts produce, and still short enough to keep the order in which the two lines switch. A step is taken on every rising clean edge of line A. The level of line B at that moment gives the direction. A full turn of the knob is 24 steps.

Top module: `quad_knob_decoder`

## Requirements
- R1: While `rst` is high, `knob_pos` is 0 and both step strobes are low, and the filters and the edge detector copy the synchronised input levels. If the knob lines are held high through reset, no step is reported after reset is released.
- R2: Each knob line passes through `SYNC_STAGES` (default 2) flops before the filter. A clean line change made just after a clock edge gives its strobe exactly `HOLD_CYCLES + 3` rising edges later.
- R3: A filtered level changes only after the synchronised input has held the new value for `HOLD_CYCLES` consecutive samples. A raw pulse of `HOLD_CYCLES - 1` cycles is ignored, and one of exactly `HOLD_CYCLES` cycles is accepted.
- R4: The hold counter of a line restarts whenever the synchronised input goes back to the current filtered level. Several short pulses that add up to more than the window, but are each shorter than it, give no step.
- R5: `knob_raw[0]` is line A and `knob_raw[1]` is line B. A clean rising edge on A while B is low is a clockwise step: `knob_pos` goes up by 1 and `step_cw` is high for one cycle.
- R6: A clean rising edge on A while B is high is a counter-clockwise step: `knob_pos` goes down by 1 and `step_ccw` is high for one cycle.
- R7: A falling edge on A, and any change on B alone, leave `knob_pos` and both strobes unchanged.
- R8: `knob_pos` wraps modulo 256. One step counter-clockwise from 0 gives 255, one step clockwise from 255 gives 0, and 24 clockwise steps add 24.
- R9: `step_cw` and `step_ccw` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| knob_raw | input | 2 | Raw contact lines: bit 0 = line A, bit 1 = line B |
| knob_pos | output | 8 | Position count, two's complement, wraps |
| step_cw | output | 1 | One-cycle pulse per clockwise step |
| step_ccw | output | 1 | One-cycle pulse per counter-clockwise step |

## Verification
A hold counter that restarts too late, or never restarts, shows up at the ports as an extra or missing step strobe. This appears one filter window after the disturbing pulse, so the bench times pulses one cycle either side of the window. A corrupted edge detector or a direction sampled from the wrong line gives a strobe on the wrong line, or a position off by one, in the very cycle the step is taken. A fault in the synchroniser depth shifts the strobe by a whole cycle, and the bench catches that with a latency check to the exact edge.

// File: rtl/qkd_pkg.sv
package qkd_pkg;

    // Outcome of one evaluation of the step detector.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_CW   = 2'd1,
        STEP_CCW  = 2'd2
    } step_e;

    // Line A rising gives a step; line B picks the direction.
    function automatic step_e classify(input logic a_now, input logic a_prev, input logic b_now);
        if (a_now && !a_prev) begin
            return b_now ? STEP_CCW : STEP_CW;
        end
        return STEP_NONE;
    endfunction

endpackage

// File: rtl/qkd_sync.sv
module qkd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    // The flops keep sampling in reset, so the filters can copy a valid level.
    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/qkd_filter.sv
module qkd_filter #(
    parameter int HOLD  = 25000,
    localparam int CNT_W = (HOLD > 2) ? $clog2(HOLD) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } flt_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    flt_t st_d;
    flt_t st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.lvl = din;
            st_d.cnt = '0;
        end else if (din == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.lvl = din;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lvl = st_q.lvl;
endmodule

// File: rtl/qkd_stepper.sv
module qkd_stepper
    import qkd_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_a,
    input  logic             line_b,
    output logic [POS_W-1:0] pos,
    output logic             cw,
    output logic             ccw
);
    typedef struct packed {
        logic             a_prev;
        logic             cw;
        logic             ccw;
        logic [POS_W-1:0] pos;
    } stp_t;

    stp_t  st_d;
    stp_t  st_q;
    step_e kind;

    always_comb begin
        kind      = classify(line_a, st_q.a_prev, line_b);
        st_d      = st_q;
        st_d.a_prev = line_a;
        st_d.cw   = 1'b0;
        st_d.ccw  = 1'b0;
        if (rst) begin
            st_d.pos = '0;
        end else begin
            case (kind)
                STEP_CW: begin
                    st_d.cw  = 1'b1;
                    st_d.pos = st_q.pos + 1'b1;
                end
                STEP_CCW: begin
                    st_d.ccw = 1'b1;
                    st_d.pos = st_q.pos - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pos = st_q.pos;
    assign cw  = st_q.cw;
    assign ccw = st_q.ccw;
endmodule

// File: rtl/quad_knob_decoder.sv
module quad_knob_decoder #(
    parameter int HOLD_CYCLES = 25000,
    parameter int SYNC_STAGES = 2,
    parameter int POS_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       knob_raw,
    output logic [POS_W-1:0] knob_pos,
    output logic             step_cw,
    output logic             step_ccw
);
    localparam int LINES = 2;
    localparam int LINE_A = 0;
    localparam int LINE_B = 1;

    logic [LINES-1:0] sync_lvl;
    logic [LINES-1:0] clean_lvl;

    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        qkd_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk (clk),
            .din (knob_raw[ln]),
            .dout(sync_lvl[ln])
        );

        qkd_filter #(
            .HOLD(HOLD_CYCLES)
        ) u_filt (
            .clk(clk),
            .rst(rst),
            .din(sync_lvl[ln]),
            .lvl(clean_lvl[ln])
        );
    end

    qkd_stepper #(
        .POS_W(POS_W)
    ) u_step (
        .clk   (clk),
        .rst   (rst),
        .line_a(clean_lvl[LINE_A]),
        .line_b(clean_lvl[LINE_B]),
        .pos   (knob_pos),
        .cw    (step_cw),
        .ccw   (step_ccw)
    );
endmodule

// File: rtl/qkd_props.sv
module qkd_props #(
    parameter int POS_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [POS_W-1:0] pos,
    input logic             cw,
    input logic             ccw,
    input logic [1:0]       sync_lvl,
    input logic [1:0]       clean_lvl
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pos == '0 && !cw && !ccw));

    assert_filter_follows_sync_R3: assert property (@(posedge clk) disable iff (rst)
        (((clean_lvl ^ $past(clean_lvl)) & (clean_lvl ^ $past(sync_lvl))) == 2'b00));

    assert_cw_increments_R5: assert property (@(posedge clk) disable iff (rst)
        cw |-> pos == $past(pos) + 1'b1);

    assert_ccw_decrements_R6: assert property (@(posedge clk) disable iff (rst)
        ccw |-> pos == $past(pos) - 1'b1);

    assert_pos_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!cw && !ccw) |-> $stable(pos));

    assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cw, ccw}));

    assert_cw_single_R9: assert property (@(posedge clk) disable iff (rst)
        cw |=> !cw);

    assert_ccw_single_R9: assert property (@(posedge clk) disable iff (rst)
        ccw |=> !ccw);
endmodule

bind quad_knob_decoder qkd_props #(
    .POS_W(POS_W)
) u_props (
    .clk      (clk),
    .rst      (rst),
    .pos      (knob_pos),
    .cw       (step_cw),
    .ccw      (step_ccw),
    .sync_lvl (sync_lvl),
    .clean_lvl(clean_lvl)
);

// File: tb/sim_quad_knob_decoder.sv
`timescale 1ns/1ps
module sim_quad_knob_decoder;
    localparam int HOLD = 8;
    localparam int SETTLE = HOLD + 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] knob_raw = 2'b00;
    logic [7:0] knob_pos;
    logic       step_cw;
    logic       step_ccw;

    int n_tests = 0;
    int n_fail  = 0;
    int cw_cnt  = 0;
    int ccw_cnt = 0;
    int viol    = 0;
    bit prev_cw = 1'b0;
    bit prev_ccw = 1'b0;
    bit done = 1'b0;

    // Fields: [17:16] raw lines {B,A}, [15:8] position, [7:4] total cw, [3:0] total ccw
    localparam logic [17:0] VEC [18] = '{
        {2'b01, 8'd1,   4'd1, 4'd0},
        {2'b11, 8'd1,   4'd1, 4'd0},
        {2'b10, 8'd1,   4'd1, 4'd0},
        {2'b00, 8'd1,   4'd1, 4'd0},
        {2'b01, 8'd2,   4'd2, 4'd0},
        {2'b11, 8'd2,   4'd2, 4'd0},
        {2'b10, 8'd2,   4'd2, 4'd0},
        {2'b00, 8'd2,   4'd2, 4'd0},
        {2'b10, 8'd2,   4'd2, 4'd0},
        {2'b11, 8'd1,   4'd2, 4'd1},
        {2'b01, 8'd1,   4'd2, 4'd1},
        {2'b00, 8'd1,   4'd2, 4'd1},
        {2'b10, 8'd1,   4'd2, 4'd1},
        {2'b11, 8'd0,   4'd2, 4'd2},
        {2'b01, 8'd0,   4'd2, 4'd2},
        {2'b00, 8'd0,   4'd2, 4'd2},
        {2'b10, 8'd0,   4'd2, 4'd2},
        {2'b11, 8'd255, 4'd2, 4'd3}
    };

    quad_knob_decoder #(
        .HOLD_CYCLES(HOLD)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .knob_raw(knob_raw),
        .knob_pos(knob_pos),
        .step_cw (step_cw),
        .step_ccw(step_ccw)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (step_cw) cw_cnt++;
            if (step_ccw) ccw_cnt++;
            if (step_cw && step_ccw) viol++;
            if ((step_cw && prev_cw) || (step_ccw && prev_ccw)) viol++;
        end
        prev_cw  = step_cw;
        prev_ccw = step_ccw;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle(input logic [1:0] v);
        knob_raw = v;
        cycles(SETTLE);
    endtask

    task automatic pulse_a(input int len);
        knob_raw[0] = 1'b1;
        cycles(len);
        knob_raw[0] = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        int base_cw;
        int base_ccw;
        @(negedge clk);
        cycles(5);
        // R1: state while reset is held
        chk(knob_pos == 8'd0, "R1 pos in reset", int'(knob_pos), 0);
        chk(!step_cw && !step_ccw, "R1 strobes in reset", int'({step_cw, step_ccw}), 0);
        rst = 1'b0;
        cycles(SETTLE);
        chk(knob_pos == 8'd0 && cw_cnt == 0 && ccw_cnt == 0, "R1 idle after reset",
            int'(knob_pos), 0);

        // Table walk: R5 cw, R6 ccw, R7 non-stepping edges, R8 wrap to 255
        foreach (VEC[i]) begin
            settle(VEC[i][17:16]);
            chk(knob_pos == VEC[i][15:8], "R5/R6/R7/R8 table position",
                int'(knob_pos), int'(VEC[i][15:8]));
            chk(cw_cnt == int'(VEC[i][7:4]) && ccw_cnt == int'(VEC[i][3:0]),
                "R5/R6 table strobe totals", cw_cnt * 16 + ccw_cnt,
                int'(VEC[i][7:4]) * 16 + int'(VEC[i][3:0]));
        end

        // Back to rest: A falls, then B falls (R7: no step)
        settle(2'b10);
        settle(2'b00);
        chk(knob_pos == 8'd255, "R7 falling edges no step", int'(knob_pos), 255);

        // R2: exact latency, and R8 wrap 255 -> 0
        knob_raw = 2'b01;
        cycles(HOLD + 2);
        chk(!step_cw, "R2 strobe not early", int'(step_cw), 0);
        cycles(1);
        chk(step_cw, "R2 strobe at HOLD+3", int'(step_cw), 1);
        chk(knob_pos == 8'd0, "R8 wrap 255 to 0", int'(knob_pos), 0);
        cycles(1);
        chk(!step_cw, "R9 strobe one cycle", int'(step_cw), 0);
        settle(2'b11);
        settle(2'b10);
        settle(2'b00);

        // R3: pulse one short of the window is ignored, exact window accepted
        base_cw = cw_cnt;
        pulse_a(HOLD - 1);
        cycles(SETTLE);
        chk(cw_cnt == base_cw && knob_pos == 8'd0, "R3 short pulse ignored",
            cw_cnt - base_cw, 0);
        pulse_a(HOLD);
        cycles(SETTLE);
        chk(cw_cnt == base_cw + 1 && knob_pos == 8'd1, "R3 full window accepted",
            cw_cnt - base_cw, 1);

        // R4: counter restarts on each return to the filtered level
        base_cw = cw_cnt;
        repeat (4) begin
            pulse_a(HOLD - 2);
            cycles(1);
        end
        cycles(SETTLE);
        chk(cw_cnt == base_cw && knob_pos == 8'd1, "R4 bounce restarts count",
            cw_cnt - base_cw, 0);

        // R7: line B toggling alone gives no step
        base_cw = cw_cnt;
        base_ccw = ccw_cnt;
        repeat (3) begin
            settle(2'b10);
            settle(2'b00);
        end
        chk(cw_cnt == base_cw && ccw_cnt == base_ccw && knob_pos == 8'd1,
            "R7 line B alone", int'(knob_pos), 1);

        // R8: one full turn of 24 clockwise steps
        base_cw = cw_cnt;
        for (int s = 0; s < 24; s++) begin
            settle(2'b01);
            settle(2'b11);
            settle(2'b10);
            settle(2'b00);
        end
        chk(knob_pos == 8'd25, "R8 full turn position", int'(knob_pos), 25);
        chk(cw_cnt == base_cw + 24, "R5 full turn strobes", cw_cnt - base_cw, 24);

        // R1: reset with both lines held high, no false step after release
        settle(2'b01);
        settle(2'b11);
        rst = 1'b1;
        cycles(4);
        chk(knob_pos == 8'd0, "R1 reset clears position", int'(knob_pos), 0);
        base_cw = cw_cnt;
        base_ccw = ccw_cnt;
        rst = 1'b0;
        cycles(3 * HOLD);
        chk(knob_pos == 8'd0 && cw_cnt == base_cw && ccw_cnt == base_ccw,
            "R1 no false step on release", int'(knob_pos), 0);

        // R9: strobe shape over the whole run
        chk(viol == 0, "R9 strobes exclusive and single", viol, 0);

        done = 1'b1;
        summary();
    end
endmodule